// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register-transfer datapath built around one internal bus. Each cycle, one source is placed on the bus, and any chosen group of registers captures that value on the next rising clock edge. The selectable sources are the four 8-bit data registers, a combinational adder that sums register 0 and register 1 modulo 256, and an external data input. Sources are picked with a one-hot vector. Targets are picked with an independent mask, so one value can be broadcast to several registers in a single cycle.

The bus is built as an AND-OR network. Each source's bits are gated by its select bit, across the full data width. The current bus value is always visible on a monitor output, and all register contents are brought out for observation.

The external input follows valid/ready rules. The block raises `ext_ready` whenever the external source is the only source selected. A transfer from the external input takes place only on an edge where `ext_valid` and `ext_ready` are both high. While the external source is selected and `ext_valid` is low, the transfer stalls: no register loads, and the same request may simply be held until valid arrives.

A select vector with two or more bits set is illegal. It blocks every write in that cycle and sets a sticky error flag.

Top module: `xfer_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four registers and `sel_err` to zero.
- R2: Select bits 0 to 3 choose registers 0 to 3. With exactly one of these bits set, `bus_mon` equals that register's value in the same cycle. With `src_sel` all zeros, `bus_mon` is zero.
- R3: Select bit 4 chooses the adder. With it alone set, `bus_mon` equals (register 0 + register 1) modulo 256.
- R4: Select bit 5 chooses the external input. With it alone set, `bus_mon` equals `ext_data`. `ext_ready` is 1 exactly when bit 5 is the only bit set in `src_sel`.
- R5: On a legal cycle, register i captures `bus_mon` at the rising edge when `dst_mask[i]` is 1. When `dst_mask[i]` is 0, register i keeps its value.
- R6: When several `dst_mask` bits are set in one legal cycle, all of the selected registers capture the same bus value on the same edge.
- R7: When `src_sel` has two or more bits set, no register changes at that edge. `sel_err` becomes 1 after that edge and stays 1 until reset.
- R8: When select bit 5 is set and `ext_valid` is 0, no register changes at that edge.
- R9: A register that is both the source and a target reloads its own value. The other targets receive the value it held before the edge.
- R10: With no source selected, the targeted registers load zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 6 | One-hot source select: bits 0-3 registers, bit 4 adder, bit 5 external |
| dst_mask | input | 4 | Target subset mask, bit i loads register i |
| ext_data | input | 8 | External source data |
| ext_valid | input | 1 | External data is valid |
| ext_ready | output | 1 | The block accepts external data this cycle |
| bus_mon | output | 8 | Current combinational bus value |
| reg_view | output | 32 | Register contents, register i at bits [8i+7:8i] |
| sel_err | output | 1 | Sticky flag for an illegal select vector |

## Verification
If a register holds a wrong value, it shows up in two places. It appears on `reg_view` one cycle after the faulty load. It also appears on `bus_mon` in the first later cycle that selects that register, or the adder when the fault is in register 0 or 1. A stuck or missed strobe shows up one edge after the cycle that targeted the register. A wrong error flag shows up on `sel_err` one edge after the illegal select. A missing hold on stall or on an illegal select shows up as a changed register in the very next cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // sources that are not registers: adder then external input
  localparam int unsigned XP_EXTRA_SRC = 2;
  localparam int unsigned XP_ADD_OFS   = 0;
  localparam int unsigned XP_EXT_OFS   = 1;
endpackage

// File: rtl/xfer_bus_sel.sv
module xfer_bus_sel #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NSRC  = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSRC-1:0]             sel,
  input  logic [NSRC-1:0][WIDTH-1:0]  src,
  output logic [WIDTH-1:0]            bus
);
  logic [NSRC-1:0][WIDTH-1:0] gated;

  // one gated driver per source, replicated over every bit
  for (genvar s = 0; s < NSRC; s++) begin : g_drv
    assign gated[s] = src[s] & {WIDTH{sel[s]}};
  end

  always_comb begin
    bus = '0;
    for (int s = 0; s < NSRC; s++) bus = bus | gated[s];
  end

  // R2: an idle bus reads as zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (bus == '0));
endmodule

// File: rtl/xfer_reg_bank.sv
module xfer_reg_bank #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NREG  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             strobe,
  input  logic [WIDTH-1:0]            din,
  output logic [NREG-1:0][WIDTH-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= '0;
      else if (strobe[i]) q[i] <= din;
    end

    // R5: strobed register captures the bus value
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
      strobe[i] |=> (q[i] == $past(din)));
    // R5: unstrobed register holds
    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
      !strobe[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_REGS+1:0]               src_sel,
  input  logic [NUM_REGS-1:0]               dst_mask,
  input  logic [DATA_W-1:0]                 ext_data,
  input  logic                              ext_valid,
  output logic                              ext_ready,
  output logic [DATA_W-1:0]                 bus_mon,
  output logic [NUM_REGS*DATA_W-1:0]        reg_view,
  output logic                              sel_err
);
  import xfer_pkg::*;

  localparam int unsigned NSRC    = NUM_REGS + XP_EXTRA_SRC;
  localparam int unsigned ADD_IDX = NUM_REGS + XP_ADD_OFS;
  localparam int unsigned EXT_IDX = NUM_REGS + XP_EXT_OFS;
  localparam int unsigned CNT_W   = $clog2(NSRC + 1);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NSRC-1:0][DATA_W-1:0]     srcs;
  logic [DATA_W-1:0]               bus;
  logic [NUM_REGS-1:0]             strobe;
  logic [CNT_W-1:0]                sel_cnt;
  logic                            multi_sel;
  logic                            ext_stall;
  logic                            write_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_src
    assign srcs[i] = regs[i];
    assign reg_view[i*DATA_W +: DATA_W] = regs[i];
  end
  assign srcs[ADD_IDX] = regs[0] + regs[1];
  assign srcs[EXT_IDX] = ext_data;

  always_comb begin
    sel_cnt = '0;
    for (int s = 0; s < NSRC; s++) sel_cnt = sel_cnt + CNT_W'(src_sel[s]);
  end

  assign multi_sel = (sel_cnt > CNT_W'(1));
  assign ext_stall = src_sel[EXT_IDX] & ~ext_valid;
  assign write_ok  = ~multi_sel & ~ext_stall;
  assign strobe    = dst_mask & {NUM_REGS{write_ok}};
  assign ext_ready = src_sel[EXT_IDX] & ~multi_sel;
  assign bus_mon   = bus;

  xfer_bus_sel #(.WIDTH(DATA_W), .NSRC(NSRC)) u_bus (
    .clk (clk),
    .rst (rst),
    .sel (src_sel),
    .src (srcs),
    .bus (bus)
  );

  xfer_reg_bank #(.WIDTH(DATA_W), .NREG(NUM_REGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .din    (bus),
    .q      (regs)
  );

  always_ff @(posedge clk) begin
    if (rst)            sel_err <= 1'b0;
    else if (multi_sel) sel_err <= 1'b1;
  end

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err);
  // R7: illegal select freezes every register
  p_multi_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_sel) > 1) |=> ($stable(regs) && sel_err));
  // R8: stalled external transfer freezes every register
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (src_sel[EXT_IDX] && !ext_valid) |=> $stable(regs));
  // R4: ready only with the external source alone
  p_ready_r4: assert property (@(posedge clk) disable iff (rst)
    ext_ready |-> (src_sel[EXT_IDX] && $onehot(src_sel)));
endmodule

// File: tb/xfer_datapath_tb.sv
module xfer_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  src_sel;
  logic [3:0]  dst_mask;
  logic [7:0]  ext_data;
  logic        ext_valid;
  logic        ext_ready;
  logic [7:0]  bus_mon;
  logic [31:0] reg_view;
  logic        sel_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_reg [4];
  logic       m_err;

  always #2 clk = ~clk;

  xfer_datapath dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .dst_mask(dst_mask),
    .ext_data(ext_data), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .bus_mon(bus_mon), .reg_view(reg_view), .sel_err(sel_err)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_bus(input logic [5:0] sel, input logic [7:0] d);
    logic [7:0] b = 8'h00;
    for (int i = 0; i < 4; i++) if (sel[i]) b = b | m_reg[i];
    if (sel[4]) b = b | (m_reg[0] + m_reg[1]);
    if (sel[5]) b = b | d;
    return b;
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < 4; i++) check(32'(reg_view[i*8 +: 8]), 32'(m_reg[i]), tag);
    check(32'(sel_err), 32'(m_err), "R7 flag");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_sel = '0; dst_mask = '0; ext_data = '0; ext_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_err = 1'b0;
    check_regs("R1");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic step(input logic [5:0] sel, input logic [3:0] msk, input logic [7:0] d,
                      input logic v, input string tag_bus, input string tag_reg);
    logic multi;
    logic [7:0] eb;
    logic wok;
    @(negedge clk);
    src_sel = sel; dst_mask = msk; ext_data = d; ext_valid = v;
    #1;
    multi = ($countones(sel) > 1);
    eb = exp_bus(sel, d);
    if (!multi) check(32'(bus_mon), 32'(eb), tag_bus);
    check(32'(ext_ready), 32'(sel[5] && !multi), "R4 ready");
    wok = !multi && !(sel[5] && !v);
    for (int i = 0; i < 4; i++) if (wok && msk[i]) m_reg[i] = eb;
    if (multi) m_err = 1'b1;
    @(posedge clk); #1;
    check_regs(tag_reg);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    do_reset();
    step(6'b000000, 4'b0000, 8'h00, 1'b0, "R2 idle", "R1");
    step(6'b100000, 4'b0001, 8'hA5, 1'b1, "R4", "R5");
    step(6'b100000, 4'b1110, 8'h3C, 1'b1, "R4", "R6");
    step(6'b010000, 4'b1000, 8'h00, 1'b0, "R3", "R5");
    step(6'b100000, 4'b0001, 8'hFF, 1'b1, "R4", "R5");
    step(6'b010000, 4'b0100, 8'h00, 1'b0, "R3 wrap", "R5");
    step(6'b000100, 4'b0111, 8'h00, 1'b0, "R2", "R9");
    step(6'b000001, 4'b1001, 8'h00, 1'b0, "R2", "R9");
    step(6'b000000, 4'b0010, 8'h55, 1'b1, "R2 idle", "R10");
    step(6'b100000, 4'b1111, 8'h77, 1'b0, "R4", "R8");
    for (int k = 0; k < 300; k++) begin
      int pick = $urandom_range(0, 6);
      logic [5:0] s = (pick == 6) ? 6'b000000 : 6'(1 << pick);
      logic [3:0] mk = 4'($urandom_range(0, 15));
      logic [7:0] dd = 8'($urandom_range(0, 255));
      logic vv = ($urandom_range(0, 3) != 0);
      string tb = (pick < 4 || pick == 6) ? "R2" : (pick == 4) ? "R3" : "R4";
      string tr = (pick == 5 && !vv) ? "R8" : "R5";
      step(s, mk, dd, vv, tb, tr);
    end
    step(6'b000011, 4'b1111, 8'h99, 1'b1, "R7", "R7");
    step(6'b100010, 4'b1111, 8'h99, 1'b1, "R7", "R7");
    step(6'b100000, 4'b0011, 8'h42, 1'b1, "R4", "R7 sticky");
    do_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule